// File: doc/BRIEF.md
# I2C Master Clock-Line Timing Generator

This block produces the clock-line waveform for an I2C master. Each period of the line has a low part and a high part. Each part's length comes from its own 8-bit count register and is scaled by a shared 8-bit prescale register. The prescaler produces a tick every (prescale + 1) clocks. A phase whose count is c lasts (c + 2) ticks, except that any count of 3 or less gives the minimum of 5 ticks.

The enable input means the controller is running as a master. While it is low the line is released (driven high) and every counter is held at zero. Software loads the three configuration registers through a simple write port. The registers accept a write only while enable is low.

A byte engine placed after this block uses the rising and falling strobes to time its data changes and sampling. A stretch input lets a slow device hold the line low at the end of a low phase.

Top module: `scl_timing_gen`

## Requirements
- R1: During reset, and while enable is low, sclDrive is 1 and neither strobe is asserted.
- R2: At the first clock edge where enable is sampled high, sclDrive goes to 0 and sclFall pulses. Every enabled run therefore begins with a low phase.
- R3: A low phase lasts max(low_count + 2, 5) × (prescale + 1) clock cycles.
- R4: A high phase lasts max(high_count + 2, 5) × (prescale + 1) clock cycles.
- R5: Count values 0, 1, 2 and 3 all give a phase of 5 × (prescale + 1) cycles.
- R6: A count of 255 gives a phase of 257 × (prescale + 1) cycles.
- R7: cfgSel selects the target register of a write: 0 is the high count, 1 is the low count, 2 is the prescale, and 3 writes nothing. A write is ignored when enable is high.
- R8: If stretchIn is high at the edge that would end a low phase, sclDrive stays 0. The high phase starts at the first edge where stretchIn is sampled low. Stretch has no effect during a high phase.
- R9: sclRise is high for exactly the one cycle in which sclDrive has just gone from 0 to 1. sclFall is high for exactly the one cycle in which sclDrive has just gone from 1 to 0. No strobe occurs at any other time.
- R10: Dropping enable releases the line on the next edge. A later enable starts a full-length low phase.
- R11: All three configuration registers reset to 0. With no writes, the line therefore runs 5 cycles low and 5 cycles high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Master operation enable; locks the configuration while high |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 high count, 1 low count, 2 prescale, 3 none |
| cfgData | input | 8 | Write data |
| stretchIn | input | 1 | Holds the line low at the end of a low phase |
| sclDrive | output | 1 | Clock-line level: 1 released, 0 pulled low |
| sclRise | output | 1 | One-cycle strobe on the low-to-high change |
| sclFall | output | 1 | One-cycle strobe on the high-to-low change |

## Verification
If the prescale or phase counter holds a wrong value, the current phase ends at the wrong time. That shows up as a wrong low or high length within one line period, at most 514 × (prescale + 1) cycles. A wrong state in the phase controller shows up sooner, on the very next edge, as a strobe without a level change, a level change without a strobe, or the line staying high after enable. A write-lock fault does not show until the next period, which then runs with the new lengths instead of the old ones.

// File: rtl/scl_gen_pkg.sv
`timescale 1ns/1ps
package scl_gen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HIGH = 2'd3
  } sclState_t;

  // Strobes from the phase control to the counting datapath
  typedef struct packed {
    logic cntClr;   // zero prescale and phase counters this cycle
    logic runHigh;  // select the high-phase length
  } phaseCtl_t;

  localparam logic [1:0] SEL_HIGH     = 2'd0;
  localparam logic [1:0] SEL_LOW      = 2'd1;
  localparam logic [1:0] SEL_PRESCALE = 2'd2;

  localparam int MIN_PHASE_TICKS = 5;
  localparam int FLOOR_COUNT     = 3;
  localparam int COUNT_OFFSET    = 2;

endpackage

// File: rtl/scl_phase_datapath.sv
`timescale 1ns/1ps
module scl_phase_datapath
  import scl_gen_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgSel,
  input  logic [CFG_W-1:0] cfgData,
  input  phaseCtl_t        ctl,
  output logic             phaseDone
);

  localparam int LEN_W = CFG_W + 1;
  localparam int NUM_PHASES = 2;  // index 0 high, 1 low
  localparam logic [CFG_W-1:0] FLOOR_VAL = CFG_W'(FLOOR_COUNT);
  localparam logic [LEN_W-1:0] MIN_LEN   = LEN_W'(MIN_PHASE_TICKS);
  localparam logic [LEN_W-1:0] OFFSET    = LEN_W'(COUNT_OFFSET);

  logic [CFG_W-1:0] countReg [NUM_PHASES];
  logic [CFG_W-1:0] prescaleReg;
  logic [LEN_W-1:0] phaseLen [NUM_PHASES];
  logic [LEN_W-1:0] curLen;
  logic [CFG_W-1:0] psCnt;
  logic [LEN_W-1:0] phCnt;
  logic             psTick;

  // Configuration registers, writable only while the block is disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countReg[0] <= '0;
      countReg[1] <= '0;
      prescaleReg <= '0;
    end else if (cfgWrEn && !enable) begin
      case (cfgSel)
        SEL_HIGH:     countReg[0] <= cfgData;
        SEL_LOW:      countReg[1] <= cfgData;
        SEL_PRESCALE: prescaleReg <= cfgData;
        default:      ;
      endcase
    end
  end

  // Per-phase length with the minimum-length floor
  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_len
    always_comb begin
      if (countReg[g] <= FLOOR_VAL) phaseLen[g] = MIN_LEN;
      else                          phaseLen[g] = {1'b0, countReg[g]} + OFFSET;
    end
  end

  assign curLen    = ctl.runHigh ? phaseLen[0] : phaseLen[1];
  assign psTick    = (psCnt == prescaleReg);
  assign phaseDone = psTick && (phCnt == curLen - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psCnt <= '0;
      phCnt <= '0;
    end else if (ctl.cntClr) begin
      psCnt <= '0;
      phCnt <= '0;
    end else if (psTick) begin
      psCnt <= '0;
      phCnt <= phCnt + LEN_W'(1);
    end else begin
      psCnt <= psCnt + CFG_W'(1);
    end
  end

endmodule

// File: rtl/scl_phase_control.sv
`timescale 1ns/1ps
module scl_phase_control
  import scl_gen_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      stretchIn,
  input  logic      phaseDone,
  output phaseCtl_t ctl,
  output logic      sclDrive,
  output logic      sclRise,
  output logic      sclFall
);

  sclState_t state, nextState;
  logic      sclReg, nextScl;

  always_comb begin
    nextState = state;
    if (!enable) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: nextState = ST_LOW;
        ST_LOW:  if (phaseDone) nextState = stretchIn ? ST_WAIT : ST_HIGH;
        ST_WAIT: if (!stretchIn) nextState = ST_HIGH;
        ST_HIGH: if (phaseDone) nextState = ST_LOW;
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assign nextScl     = (nextState == ST_HIGH) || (nextState == ST_IDLE);
  assign ctl.cntClr  = (state != nextState) || (state == ST_IDLE) || (state == ST_WAIT);
  assign ctl.runHigh = (state == ST_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sclReg  <= 1'b1;
      sclRise <= 1'b0;
      sclFall <= 1'b0;
    end else begin
      state   <= nextState;
      sclReg  <= nextScl;
      sclRise <= nextScl && !sclReg;
      sclFall <= !nextScl && sclReg;
    end
  end

  assign sclDrive = sclReg;

endmodule

// File: rtl/scl_timing_gen.sv
`timescale 1ns/1ps
module scl_timing_gen
  import scl_gen_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgSel,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             stretchIn,
  output logic             sclDrive,
  output logic             sclRise,
  output logic             sclFall
);

  phaseCtl_t ctl;
  logic      phaseDone;

  scl_phase_datapath #(.CFG_W(CFG_W)) i_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgData   (cfgData),
    .ctl       (ctl),
    .phaseDone (phaseDone)
  );

  scl_phase_control i_control (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .stretchIn (stretchIn),
    .phaseDone (phaseDone),
    .ctl       (ctl),
    .sclDrive  (sclDrive),
    .sclRise   (sclRise),
    .sclFall   (sclFall)
  );

endmodule

// File: rtl/scl_timing_gen_checker.sv
`timescale 1ns/1ps
module scl_timing_gen_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic stretchIn,
  input logic sclDrive,
  input logic sclRise,
  input logic sclFall
);

  localparam int RUN_W = 16;
  logic [RUN_W-1:0] lowRun;

  // Cycles the line has been low, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lowRun <= '0;
    else if (sclDrive)        lowRun <= '0;
    else if (lowRun != '1)    lowRun <= lowRun + RUN_W'(1);
  end

  AST_DISABLED_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> sclDrive);  // R10

  AST_ENABLE_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> (sclFall && !sclDrive));  // R2

  AST_FALL_MATCHES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    sclFall |-> (!sclDrive && $past(sclDrive)));  // R9

  AST_RISE_MATCHES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    sclRise |-> (sclDrive && !$past(sclDrive)));  // R9

  AST_CHANGE_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (sclDrive != $past(sclDrive)) |-> (sclRise || sclFall));  // R9

  AST_STRETCH_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (sclRise && $past(enable)) |-> !$past(stretchIn));  // R8

  AST_MIN_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sclRise && $past(enable)) |-> (lowRun >= RUN_W'(5)));  // R5

endmodule

bind scl_timing_gen scl_timing_gen_checker i_sclChecker (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .stretchIn (stretchIn),
  .sclDrive  (sclDrive),
  .sclRise   (sclRise),
  .sclFall   (sclFall)
);

// File: tb/test_scl_timing_gen.sv
`timescale 1ns/1ps
module test_scl_timing_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [1:0] cfgSel = 2'd0;
  logic [7:0] cfgData = 8'd0;
  logic       stretchIn = 1'b0;
  logic       sclDrive, sclRise, sclFall;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  scl_timing_gen i_scl_timing_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgData   (cfgData),
    .stretchIn (stretchIn),
    .sclDrive  (sclDrive),
    .sclRise   (sclRise),
    .sclFall   (sclFall)
  );

  typedef struct packed {
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [7:0]  ps;
    logic [15:0] expHigh;
    logic [15:0] expLow;
  } vec_t;

  localparam int NUM_VECS = 6;
  localparam vec_t VECS [NUM_VECS] = '{
    '{8'd4,   8'd6,   8'd0, 16'd6,   16'd8},
    '{8'd0,   8'd1,   8'd1, 16'd10,  16'd10},
    '{8'd3,   8'd3,   8'd2, 16'd15,  16'd15},
    '{8'd10,  8'd2,   8'd3, 16'd48,  16'd20},
    '{8'd255, 8'd0,   8'd0, 16'd257, 16'd5},
    '{8'd7,   8'd255, 8'd1, 16'd18,  16'd514}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // All tasks begin and end just after a falling clock edge
  task automatic writeCfg(input logic [1:0] sel, input logic [7:0] data);
    cfgWrEn = 1'b1;
    cfgSel  = sel;
    cfgData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // Called at the cycle showing sclFall; counts low then high cycles
  task automatic measureFromFall(output int lowC, output int highC);
    int extra = 0;
    lowC = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (sclRise) break;
      if (sclFall) extra++;
      lowC++;
    end
    highC = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (sclFall) break;
      if (sclRise) extra++;
      highC++;
    end
    check(extra == 0, "R9", "strobe outside its edge cycle", extra, 0);
  endtask

  task automatic enableAndFall();
    enable = 1'b1;
    @(negedge clk);
    check(sclFall && !sclDrive, "R2", "fall strobe after enable",
          int'(sclFall), 1);
  endtask

  task automatic waitFall();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (sclFall) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lowC, highC;
    bit ok;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(sclDrive && !sclRise && !sclFall, "R1", "line during reset",
          int'(sclDrive), 1);
    rst_n = 1'b1;
    ok = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (!sclDrive || sclRise || sclFall) ok = 1'b0;
    end
    check(ok, "R1", "line released while disabled", int'(ok), 1);

    // R11: reset values give 5/5
    enableAndFall();
    measureFromFall(lowC, highC);
    check(lowC == 5, "R11", "default low length", lowC, 5);
    check(highC == 5, "R11", "default high length", highC, 5);
    enable = 1'b0;
    @(negedge clk);
    check(sclDrive == 1'b1, "R10", "release after disable", int'(sclDrive), 1);

    // Vector table: R3/R4 lengths, R5 floor, R6 maximum
    for (int v = 0; v < NUM_VECS; v++) begin
      writeCfg(2'd0, VECS[v].hi);
      writeCfg(2'd1, VECS[v].lo);
      writeCfg(2'd2, VECS[v].ps);
      enableAndFall();
      measureFromFall(lowC, highC);
      check(lowC == int'(VECS[v].expLow), "R3",
            $sformatf("low length vec %0d (R5/R6)", v), lowC, int'(VECS[v].expLow));
      check(highC == int'(VECS[v].expHigh), "R4",
            $sformatf("high length vec %0d (R5/R6)", v), highC, int'(VECS[v].expHigh));
      enable = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R7: select 3 writes nothing, writes locked while enabled
    writeCfg(2'd0, 8'd4);
    writeCfg(2'd1, 8'd4);
    writeCfg(2'd2, 8'd0);
    writeCfg(2'd3, 8'hFF);
    enableAndFall();
    measureFromFall(lowC, highC);
    check(lowC == 6 && highC == 6, "R7", "select 3 ignored (low)", lowC, 6);
    writeCfg(2'd0, 8'd200);
    writeCfg(2'd1, 8'd200);
    writeCfg(2'd2, 8'd5);
    waitFall();
    measureFromFall(lowC, highC);
    check(lowC == 6, "R7", "locked low length", lowC, 6);
    check(highC == 6, "R7", "locked high length", highC, 6);
    enable = 1'b0;
    repeat (2) @(negedge clk);

    // R8: stretch at end of low phase
    writeCfg(2'd0, 8'd2);
    writeCfg(2'd1, 8'd2);
    enableAndFall();
    stretchIn = 1'b1;
    ok = 1'b1;
    repeat (19) begin
      @(negedge clk);
      if (sclDrive || sclRise) ok = 1'b0;
    end
    check(ok, "R8", "line held low by stretch", int'(ok), 1);
    stretchIn = 1'b0;
    @(negedge clk);
    check(sclRise && sclDrive, "R8", "rise after stretch release",
          int'(sclRise), 1);
    stretchIn = 1'b1;  // no effect during high
    highC = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sclFall) break;
      highC++;
    end
    check(highC == 5, "R8", "stretch ignored in high phase", highC, 5);
    stretchIn = 1'b0;

    // R10: disable mid low phase, then restart
    repeat (2) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(sclDrive && sclRise, "R10", "release with rise strobe",
          int'(sclDrive), 1);
    @(negedge clk);
    check(!sclRise && sclDrive, "R9", "rise strobe one cycle", int'(sclRise), 0);
    enableAndFall();
    measureFromFall(lowC, highC);
    check(lowC == 5, "R10", "full low after re-enable", lowC, 5);
    enable = 1'b0;
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule